// File: doc/BRIEF.md
# Translation Lookaside Buffer with Most-Recently-Used Bit Replacement

This block caches translations from 32-bit virtual addresses to physical frames for a load/store/fetch path. It is fully associative and holds up to 32 entries. Each entry holds a virtual page tag, a size code, a physical frame number and an 8-bit flag byte. The size code selects either a 4 KiB page (12 offset bits) or a 4 MiB page (22 offset bits). Both sizes live in the same array. Each entry compares the incoming address only above its own offset width.

A lookup is answered combinationally, in the cycle the request is presented. The answer is exactly one of hit, miss or permission fault. A hit also returns the frame number, the page size, the flag byte and the assembled physical address. After a page-table walk elsewhere, the new translation is written through a fill port, and the write takes effect at the next clock edge. A flush input empties the whole buffer in one cycle.

Replacement keeps one most-recently-used bit per entry. Fills, hits and a filling buffer clear or set these bits under fixed rules. A fill into a full buffer evicts the lowest-index entry whose bit is clear and increments an eviction counter. The fill side must not insert a page that is already present.

Top module: `tlb_xlat`

## Requirements
- R1: After reset every entry is invalid, every lookup reports a miss, and the eviction counter reads zero.
- R2: A 4 KiB entry (fl_big=0) matches a lookup whose address bits [31:12] equal its stored page number. The hit returns lk_pfn equal to the filled frame, lk_big=0, and lk_paddr = {frame, address[11:0]}.
- R3: A 4 MiB entry (fl_big=1) matches when address bits [31:22] equal bits [19:10] of its stored page number, ignoring address bits [21:12]. The hit returns lk_big=1 and lk_paddr = {frame[21:10], address[21:0]}.
- R4: The flag byte has V at bit 0, R at bit 1, W at bit 2 and X at bit 3, and lk_type encodes 0 as load, 1 as store and 2 as fetch. A matched load needs R, a matched store needs W, and a matched fetch needs both R and X; type 3 always faults. A matched lookup that lacks its permission raises lk_fault instead of lk_hit.
- R5: While lk_valid is high, exactly one of lk_hit, lk_miss and lk_fault is high in the same cycle. While lk_valid is low, all three are low.
- R6: A newly filled entry starts with its most-recently-used bit set.
- R7: A matched lookup into a full buffer leaves only the matched entry's bit set. In a buffer that is not full, the matched entry's bit is set and the others are kept.
- R8: A fill into a buffer holding exactly 31 valid entries first clears every most-recently-used bit.
- R9: A flush invalidates all entries at the next edge. A fill presented in the flush cycle is dropped, and a lookup in the flush cycle reports a miss.
- R10: When a fill and a lookup are presented in the same cycle, the fill is written, and the lookup reports a miss and leaves the replacement bits unchanged.
- R11: A fill into a full buffer replaces the lowest-index entry with a clear bit (entry 0 if none is clear) and increments evict_cnt by one. Fills into a non-full buffer, and flushes, leave evict_cnt unchanged.
- R12: A lookup that matches an entry but faults still counts as a use of that entry for replacement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_type | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| lk_hit | output | 1 | Translation found with permission |
| lk_miss | output | 1 | No usable match |
| lk_fault | output | 1 | Match found without permission |
| lk_big | output | 1 | Hit is a 4 MiB page |
| lk_pfn | output | 22 | Frame number of the hit |
| lk_paddr | output | 34 | Physical address of the hit |
| lk_flags | output | 8 | Flag byte of the hit |
| fl_valid | input | 1 | Fill request |
| fl_vpn | input | 20 | Virtual page number (address bits [31:12]) to insert |
| fl_big | input | 1 | Fill is a 4 MiB page |
| fl_pfn | input | 22 | Frame number to insert |
| fl_flags | input | 8 | Flag byte to insert |
| evict_cnt | output | 16 | Count of fills that displaced a valid entry |

## Verification
The bench drives the replacement bits through one sequence in which every rule changes which entry a later fill evicts. It then probes the displaced page with a miss, which does not disturb the bits. If the rule that clears all bits at 31 entries were missing, the fallback victim would be entry 0 twice. If the full-buffer hit rule were missing, or fills did not set their own bit, or faulting matches were not counted as uses, a page further up the array would be evicted and the page expected to be gone would still hit. Page-size handling is probed with addresses just inside and just outside a 4 MiB region, where a design comparing the wrong field width hits or misses wrongly. Fill colliding with a lookup, and a fill arriving during a flush, are also checked: a wrong priority shows up as a spurious hit or a surviving entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  localparam int SMALL_OFS = 12;
  localparam int BIG_OFS   = 22;
  localparam int SIZE_GAP  = BIG_OFS - SMALL_OFS;

  localparam int FLG_V = 0;
  localparam int FLG_R = 1;
  localparam int FLG_W = 2;
  localparam int FLG_X = 3;

endpackage

// File: rtl/tlb_rst_sync.sv
module tlb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N     = 32,
  parameter int VPN_W = 20,
  parameter int PFN_W = 22,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [VPN_W-1:0]            wr_vpn,
  input  logic                        wr_big,
  input  logic [PFN_W-1:0]            wr_pfn,
  input  logic [7:0]                  wr_flags,
  output logic [N-1:0][VPN_W-1:0]     vpn_q,
  output logic [N-1:0]                big_q,
  output logic [N-1:0][PFN_W-1:0]     pfn_q,
  output logic [N-1:0][7:0]           flags_q
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (slot_we) begin
        vpn_q[g]   <= wr_vpn;
        big_q[g]   <= wr_big;
        pfn_q[g]   <= wr_pfn;
        flags_q[g] <= wr_flags;
      end
    end
  end

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N     = 32,
  parameter int VA_W  = 32,
  parameter int PFN_W = 22,
  localparam int VPN_W = VA_W - tlb_pkg::SMALL_OFS,
  localparam int HI_W  = VA_W - tlb_pkg::BIG_OFS
) (
  input  logic [VA_W-1:0]             vaddr,
  input  logic [N-1:0]                valid_q,
  input  logic [N-1:0][VPN_W-1:0]     vpn_q,
  input  logic [N-1:0]                big_q,
  input  logic [N-1:0][PFN_W-1:0]     pfn_q,
  input  logic [N-1:0][7:0]           flags_q,
  output logic [N-1:0]                match_vec,
  output logic                        match_any,
  output logic                        sel_big,
  output logic [PFN_W-1:0]            sel_pfn,
  output logic [7:0]                  sel_flags
);
  import tlb_pkg::*;

  logic [VPN_W-1:0] va_small;
  logic [HI_W-1:0]  va_big;

  assign va_small = vaddr[VA_W-1:SMALL_OFS];
  assign va_big   = vaddr[VA_W-1:BIG_OFS];

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic small_eq;
    logic big_eq;
    assign small_eq     = (vpn_q[g] == va_small);
    assign big_eq       = (vpn_q[g][VPN_W-1:SIZE_GAP] == va_big);
    assign match_vec[g] = valid_q[g] && (big_q[g] ? big_eq : small_eq);
  end

  assign match_any = |match_vec;

  always_comb begin
    sel_big   = 1'b0;
    sel_pfn   = '0;
    sel_flags = '0;
    for (int i = 0; i < N; i++) begin
      sel_big   = sel_big   | (match_vec[i] & big_q[i]);
      sel_pfn   = sel_pfn   | ({PFN_W{match_vec[i]}} & pfn_q[i]);
      sel_flags = sel_flags | ({8{match_vec[i]}} & flags_q[i]);
    end
  end

endmodule

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk (
  input  logic [1:0] acc_type,
  input  logic       perm_r,
  input  logic       perm_w,
  input  logic       perm_x,
  output logic       allowed
);
  import tlb_pkg::*;

  acc_t kind;
  assign kind = acc_t'(acc_type);

  always_comb begin
    unique case (kind)
      ACC_LOAD:  allowed = perm_r;
      ACC_STORE: allowed = perm_w;
      ACC_FETCH: allowed = perm_r & perm_x;
      default:   allowed = 1'b0;
    endcase
  end

endmodule

// File: rtl/tlb_mru_ctl.sv
module tlb_mru_ctl #(
  parameter int N     = 32,
  parameter int CNT_W = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int OCC_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill_en,
  input  logic             use_en,
  input  logic [N-1:0]     use_vec,
  output logic [N-1:0]     valid_q,
  output logic [IDX_W-1:0] fill_idx,
  output logic [CNT_W-1:0] evict_q
);

  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(N);
  localparam logic [OCC_W-1:0] OCC_NEAR = OCC_W'(N - 1);

  logic [N-1:0]     mru_q;
  logic [N-1:0]     valid_d;
  logic [N-1:0]     mru_d;
  logic [CNT_W-1:0] evict_d;
  logic [OCC_W-1:0] occupancy;
  logic             is_full;
  logic             is_near;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] cold_idx;
  logic             cold_found;
  logic             upd_en;

  always_comb begin
    occupancy = '0;
    for (int i = 0; i < N; i++) begin
      occupancy = occupancy + {{IDX_W{1'b0}}, valid_q[i]};
    end
  end

  assign is_full = (occupancy == OCC_FULL);
  assign is_near = (occupancy == OCC_NEAR);

  // lowest-index empty slot and lowest-index slot with a clear use bit
  always_comb begin
    free_idx   = '0;
    cold_idx   = '0;
    cold_found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_idx = IDX_W'(i);
      end
      if (!mru_q[i]) begin
        cold_idx   = IDX_W'(i);
        cold_found = 1'b1;
      end
    end
  end

  assign fill_idx = is_full ? (cold_found ? cold_idx : '0) : free_idx;

  always_comb begin
    valid_d = valid_q;
    mru_d   = mru_q;
    evict_d = evict_q;
    if (flush) begin
      valid_d = '0;
      mru_d   = '0;
    end else if (fill_en) begin
      if (is_near) begin
        mru_d = '0;
      end
      mru_d[fill_idx]   = 1'b1;
      valid_d[fill_idx] = 1'b1;
      if (is_full) begin
        evict_d = evict_q + 1'b1;
      end
    end else if (use_en) begin
      mru_d = is_full ? use_vec : (mru_q | use_vec);
    end
  end

  assign upd_en = flush | fill_en | use_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      mru_q   <= '0;
      evict_q <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      mru_q   <= mru_d;
      evict_q <= evict_d;
    end
  end

endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat #(
  parameter int N_ENTRIES = 32,
  parameter int VA_W      = 32,
  parameter int PFN_W     = 22,
  parameter int CNT_W     = 16,
  localparam int VPN_W    = VA_W - tlb_pkg::SMALL_OFS,
  localparam int PA_W     = PFN_W + tlb_pkg::SMALL_OFS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_type,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_fault,
  output logic             lk_big,
  output logic [PFN_W-1:0] lk_pfn,
  output logic [PA_W-1:0]  lk_paddr,
  output logic [7:0]       lk_flags,
  input  logic             fl_valid,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic             fl_big,
  input  logic [PFN_W-1:0] fl_pfn,
  input  logic [7:0]       fl_flags,
  output logic [CNT_W-1:0] evict_cnt
);
  import tlb_pkg::*;

  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic                              rst_core_n;
  logic [N_ENTRIES-1:0]              valid_q;
  logic [IDX_W-1:0]                  fill_idx;
  logic [N_ENTRIES-1:0][VPN_W-1:0]   vpn_q;
  logic [N_ENTRIES-1:0]              big_q;
  logic [N_ENTRIES-1:0][PFN_W-1:0]   pfn_q;
  logic [N_ENTRIES-1:0][7:0]         flags_q;
  logic [N_ENTRIES-1:0]              match_vec;
  logic                              match_any;
  logic                              sel_big;
  logic [PFN_W-1:0]                  sel_pfn;
  logic [7:0]                        sel_flags;
  logic                              perm_ok;
  logic                              lk_accept;
  logic                              fill_do;
  logic                              use_en;
  logic                              found;

  tlb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // flush outranks fill, fill outranks lookup
  assign fill_do   = fl_valid & ~flush;
  assign lk_accept = lk_valid & ~fl_valid & ~flush;

  tlb_mru_ctl #(.N(N_ENTRIES), .CNT_W(CNT_W)) u_mru (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .flush    (flush),
    .fill_en  (fill_do),
    .use_en   (use_en),
    .use_vec  (match_vec),
    .valid_q  (valid_q),
    .fill_idx (fill_idx),
    .evict_q  (evict_cnt)
  );

  tlb_store #(.N(N_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk      (clk),
    .wr_en    (fill_do),
    .wr_idx   (fill_idx),
    .wr_vpn   (fl_vpn),
    .wr_big   (fl_big),
    .wr_pfn   (fl_pfn),
    .wr_flags (fl_flags),
    .vpn_q    (vpn_q),
    .big_q    (big_q),
    .pfn_q    (pfn_q),
    .flags_q  (flags_q)
  );

  tlb_cam #(.N(N_ENTRIES), .VA_W(VA_W), .PFN_W(PFN_W)) u_cam (
    .vaddr     (lk_vaddr),
    .valid_q   (valid_q),
    .vpn_q     (vpn_q),
    .big_q     (big_q),
    .pfn_q     (pfn_q),
    .flags_q   (flags_q),
    .match_vec (match_vec),
    .match_any (match_any),
    .sel_big   (sel_big),
    .sel_pfn   (sel_pfn),
    .sel_flags (sel_flags)
  );

  tlb_perm_chk u_perm (
    .acc_type (lk_type),
    .perm_r   (sel_flags[FLG_R]),
    .perm_w   (sel_flags[FLG_W]),
    .perm_x   (sel_flags[FLG_X]),
    .allowed  (perm_ok)
  );

  assign found    = lk_accept & match_any;
  assign use_en   = found;
  assign lk_hit   = found & perm_ok;
  assign lk_fault = found & ~perm_ok;
  assign lk_miss  = lk_valid & ~found;
  assign lk_big   = lk_hit & sel_big;
  assign lk_pfn   = lk_hit ? sel_pfn : '0;
  assign lk_flags = lk_hit ? sel_flags : '0;

  always_comb begin
    if (!lk_hit) begin
      lk_paddr = '0;
    end else if (sel_big) begin
      lk_paddr = {sel_pfn[PFN_W-1:SIZE_GAP], lk_vaddr[BIG_OFS-1:0]};
    end else begin
      lk_paddr = {sel_pfn, lk_vaddr[SMALL_OFS-1:0]};
    end
  end

endmodule

// File: rtl/tlb_xlat_chk.sv
module tlb_xlat_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             lk_valid,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_fault,
  input logic             fl_valid,
  input logic [CNT_W-1:0] evict_cnt
);

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ($countones({lk_hit, lk_miss, lk_fault}) == 1)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_fault)); // R5

  AST_FILL_BEATS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && fl_valid) |-> lk_miss); // R10

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (lk_valid |-> lk_miss)); // R9

  AST_EVICT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_valid |=> $stable(evict_cnt)); // R11

  AST_EVICT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |=> (evict_cnt == $past(evict_cnt)) ||
                 (evict_cnt == $past(evict_cnt) + 1'b1)); // R11

endmodule

bind tlb_xlat tlb_xlat_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .lk_valid  (lk_valid),
  .lk_hit    (lk_hit),
  .lk_miss   (lk_miss),
  .lk_fault  (lk_fault),
  .fl_valid  (fl_valid),
  .evict_cnt (evict_cnt)
);

// File: tb/tlb_xlat_test.sv
module tlb_xlat_test;

  localparam int PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        flush;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_type;
  logic        lk_hit, lk_miss, lk_fault, lk_big;
  logic [21:0] lk_pfn;
  logic [33:0] lk_paddr;
  logic [7:0]  lk_flags;
  logic        fl_valid;
  logic [19:0] fl_vpn;
  logic        fl_big;
  logic [21:0] fl_pfn;
  logic [7:0]  fl_flags;
  logic [15:0] evict_cnt;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic        s_hit, s_miss, s_fault, s_big;
  logic [21:0] s_pfn;
  logic [33:0] s_paddr;

  tlb_xlat uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_type(lk_type),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_big(lk_big),
    .lk_pfn(lk_pfn), .lk_paddr(lk_paddr), .lk_flags(lk_flags),
    .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_big(fl_big), .fl_pfn(fl_pfn),
    .fl_flags(fl_flags), .evict_cnt(evict_cnt)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] va, input logic big,
                      input logic [21:0] pfn, input logic [7:0] flg);
    @(negedge clk);
    fl_valid = 1'b1; fl_vpn = va[31:12]; fl_big = big; fl_pfn = pfn; fl_flags = flg;
    @(negedge clk);
    fl_valid = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] ty);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_type = ty;
    #1;
    s_hit = lk_hit; s_miss = lk_miss; s_fault = lk_fault;
    s_big = lk_big; s_pfn = lk_pfn; s_paddr = lk_paddr;
    @(posedge clk);
    #1 lk_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  function automatic logic [2:0] outcome();
    return {s_hit, s_miss, s_fault};
  endfunction

  localparam logic [2:0] HIT = 3'b100, MISS = 3'b010, FAULT = 3'b001;

  task automatic t_reset();
    check("R1", "evict after reset", evict_cnt, 0);
    lookup(32'h0000_0000, 2'd0);
    check("R1", "lookup after reset", outcome(), MISS);
    lookup(32'hFFFF_F000, 2'd2);
    check("R1", "fetch after reset", outcome(), MISS);
  endtask

  task automatic t_small();
    fill(32'h0004_5000, 1'b0, 22'h12345, 8'h0F);
    lookup(32'h0004_5FFC, 2'd0);
    check("R2", "small hit", outcome(), HIT);
    check("R2", "small pfn", s_pfn, 22'h12345);
    check("R2", "small paddr", s_paddr, 34'h0_1234_5FFC);
    check("R2", "small size", s_big, 1'b0);
    lookup(32'h0004_6000, 2'd0);
    check("R2", "next page", outcome(), MISS);
    lookup(32'h1004_5000, 2'd0);
    check("R2", "high bits differ", outcome(), MISS);
  endtask

  task automatic t_big();
    fill(32'h1240_0000, 1'b1, 22'h12C00, 8'h0F);
    lookup(32'h127F_FFFC, 2'd0);
    check("R3", "big hit at top", outcome(), HIT);
    check("R3", "big size", s_big, 1'b1);
    check("R3", "big paddr", s_paddr, 34'h0_12FF_FFFC);
    lookup(32'h1240_1004, 2'd2);
    check("R3", "big hit low", outcome(), HIT);
    lookup(32'h1280_0000, 2'd0);
    check("R3", "past region", outcome(), MISS);
    lookup(32'h123F_FFFC, 2'd0);
    check("R3", "below region", outcome(), MISS);
  endtask

  task automatic t_perm();
    fill(32'h0001_0000, 1'b0, 22'h100, 8'h0B);
    fill(32'h0001_1000, 1'b0, 22'h101, 8'h07);
    fill(32'h0001_2000, 1'b0, 22'h102, 8'h09);
    fill(32'h0001_3000, 1'b0, 22'h103, 8'h03);
    lookup(32'h0001_0000, 2'd2); check("R4", "fetch RX", outcome(), HIT);
    lookup(32'h0001_0000, 2'd0); check("R4", "load RX", outcome(), HIT);
    lookup(32'h0001_0000, 2'd1); check("R4", "store RX", outcome(), FAULT);
    lookup(32'h0001_1000, 2'd2); check("R4", "fetch RW", outcome(), FAULT);
    lookup(32'h0001_1000, 2'd1); check("R4", "store RW", outcome(), HIT);
    lookup(32'h0001_2000, 2'd2); check("R4", "fetch X only", outcome(), FAULT);
    lookup(32'h0001_2000, 2'd0); check("R4", "load X only", outcome(), FAULT);
    lookup(32'h0001_3000, 2'd2); check("R4", "fetch R only", outcome(), FAULT);
    lookup(32'h0001_0000, 2'd3); check("R4", "type 3", outcome(), FAULT);
  endtask

  task automatic t_idle();
    @(negedge clk);
    lk_vaddr = 32'h0004_5000; lk_type = 2'd0;
    #1;
    check("R5", "idle outputs", {lk_hit, lk_miss, lk_fault}, 3'b000);
  endtask

  task automatic t_collide();
    @(negedge clk);
    fl_valid = 1'b1; fl_vpn = 20'h00005; fl_big = 1'b0; fl_pfn = 22'h55; fl_flags = 8'h0F;
    lk_valid = 1'b1; lk_vaddr = 32'h0000_5000; lk_type = 2'd0;
    #1;
    check("R10", "collide lookup", {lk_hit, lk_miss, lk_fault}, MISS);
    @(posedge clk);
    #1 fl_valid = 1'b0; lk_valid = 1'b0;
    lookup(32'h0000_5000, 2'd0);
    check("R10", "fill kept", outcome(), HIT);
    check("R10", "fill pfn", s_pfn, 22'h55);
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1'b1; lk_valid = 1'b1; lk_vaddr = 32'h0004_5000; lk_type = 2'd0;
    fl_valid = 1'b1; fl_vpn = 20'h00777; fl_big = 1'b0; fl_pfn = 22'h7; fl_flags = 8'h0F;
    #1;
    check("R9", "lookup during flush", {lk_hit, lk_miss, lk_fault}, MISS);
    @(posedge clk);
    #1 flush = 1'b0; lk_valid = 1'b0; fl_valid = 1'b0;
    lookup(32'h0004_5000, 2'd0); check("R9", "small gone", outcome(), MISS);
    lookup(32'h1240_0000, 2'd0); check("R9", "big gone", outcome(), MISS);
    lookup(32'h0077_7000, 2'd0); check("R9", "fill in flush dropped", outcome(), MISS);
    check("R11", "flush keeps evict", evict_cnt, 0);
  endtask

  task automatic t_replace();
    do_flush();
    for (int i = 0; i < 32; i++) begin
      fill(32'h0010_0000 + (i << 12), 1'b0, 22'(i), 8'h0B);
    end
    check("R11", "no eviction while filling", evict_cnt, 0);
    fill(32'h0020_0000, 1'b0, 22'h200, 8'h0B);
    fill(32'h0020_1000, 1'b0, 22'h201, 8'h0B);
    check("R11", "two evictions", evict_cnt, 2);
    lookup(32'h0010_1000, 2'd0); check("R8", "slot 1 evicted", outcome(), MISS);
    lookup(32'h0010_0000, 2'd0); check("R8", "slot 0 evicted", outcome(), MISS);
    lookup(32'h0010_5000, 2'd0); check("R7", "hit slot 5", outcome(), HIT);
    fill(32'h0020_2000, 1'b0, 22'h202, 8'h0B);
    lookup(32'h0020_0000, 2'd0); check("R7", "slot 0 reused", outcome(), MISS);
    fill(32'h0020_3000, 1'b0, 22'h203, 8'h0B);
    lookup(32'h0020_1000, 2'd0); check("R6", "new entry kept, slot 1 reused", outcome(), MISS);
    lookup(32'h0010_3000, 2'd1); check("R12", "store faults", outcome(), FAULT);
    fill(32'h0020_4000, 1'b0, 22'h204, 8'h0B);
    lookup(32'h0020_2000, 2'd0); check("R12", "fault counted as use", outcome(), MISS);
    check("R11", "five evictions", evict_cnt, 5);
    lookup(32'h0010_2000, 2'd0); check("R12", "slot 2 survives", outcome(), HIT);
    lookup(32'h0020_4000, 2'd0); check("R11", "victim written", outcome(), HIT);
    check("R11", "victim pfn", s_pfn, 22'h204);
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; lk_type = '0;
    fl_valid = 1'b0; fl_vpn = '0; fl_big = 1'b0; fl_pfn = '0; fl_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_small();
    t_big();
    t_perm();
    t_idle();
    t_collide();
    t_flush();
    t_replace();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

endmodule